// File: doc/BRIEF.md
# Shared memory window bridge

This block lets a 16-bit, byte-addressed host look into the 24-bit word memory of a DSP through a window of fixed size. Every DSP word takes two host byte addresses, and the host data path carries only the upper sixteen bits of each word. The lowest byte stays private to the DSP. A bank select picks which half of the DSP memory appears in the window. The DSP sees all of it through its own port at DSP addresses 0x4000 to 0xBFFF.

A small write-only control byte in the host I/O space does three jobs. It turns window decoding on or off, it chooses the bank, and it drives the DSP reset line. A read of the same I/O offset returns a board information byte, but only while the DSP is held in reset.

The memory itself sits outside the block as a single-port array with one cycle of read latency. The bridge arbitrates for it, and a host access always wins. A DSP request that arrives in the same cycle is told to wait and completes on the next cycle in which the host does not use the memory.

Top module: `smw_bridge`

## Requirements
- R1: After reset, dsp_rst_n is 0, the window is disabled and the bank select is 0.
- R2: A write to I/O offset 4 loads the control byte. Bit 2 is an active-low window enable, bit 1 drives dsp_rst_n (1 = DSP running) and bit 0 is the bank select. Bits 7:3 are ignored, and writes to any other offset leave the control state unchanged.
- R3: With bank 0, the host byte offset h maps to DSP word address 0x4000 + (h >> 1). For example, host 0x2400 and host 0x2401 both reach DSP 0x5200.
- R4: With bank 1, the host byte offset h maps to DSP word address 0x8000 + (h >> 1).
- R5: A DSP address a in 0x4000 to 0xBFFF selects memory word a − 0x4000. Both ends of that range are reachable.
- R6: A host read returns bits 23:8 of the selected word on hm_rdata, with hm_rvalid high, in the cycle after the request.
- R7: On a host write, hm_be[1] updates bits 23:16 from hm_wdata[15:8] and hm_be[0] updates bits 15:8 from hm_wdata[7:0]. Bits 7:0 of the word keep their stored value.
- R8: While the window is disabled, host requests cause no memory access and never stall the DSP. hm_rvalid stays 0 and hm_rdata reads 0.
- R9: When the host (with the window enabled) and the DSP request in the same cycle, the host access is performed and dsp_wait is high in that cycle. A DSP request held through the wait is performed in the next cycle free of host access.
- R10: A DSP read returns all 24 bits of the word on dsp_rdata, with dsp_rvalid high, in the cycle after the access is performed.
- R11: A read of I/O offset 4 while dsp_rst_n is 0 returns {version[3:0], 1, board type, board revision[1:0]}, which is 0x3A with the default parameters. While the DSP runs, that read returns 0x00, and other offsets always read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_wr | input | 1 | Host I/O write strobe |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | 3 | Host I/O offset |
| io_wdata | input | 8 | Host I/O write data |
| io_rdata | output | 8 | Host I/O read data (board information) |
| dsp_rst_n | output | 1 | DSP reset, low holds the DSP in reset |
| hm_req | input | 1 | Host window access request |
| hm_we | input | 1 | Host write when 1, read when 0 |
| hm_addr | input | 15 | Host byte offset in the window |
| hm_be | input | 2 | Host byte lane enables (1 = bits 23:16, 0 = bits 15:8) |
| hm_wdata | input | 16 | Host write data |
| hm_rdata | output | 16 | Host read data, bits 23:8 of the word |
| hm_rvalid | output | 1 | Host read data valid |
| dsp_req | input | 1 | DSP memory request, held while dsp_wait is high |
| dsp_we | input | 1 | DSP write when 1 |
| dsp_addr | input | 16 | DSP word address |
| dsp_wdata | input | 24 | DSP write data |
| dsp_rdata | output | 24 | DSP read data |
| dsp_rvalid | output | 1 | DSP read data valid |
| dsp_wait | output | 1 | DSP access held off this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_be | output | 3 | Memory byte enables, bit 2 = bits 23:16 |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, one cycle after a read |

## Verification
The two functions that can meet in one cycle are a host window access and a DSP memory access. The bench provokes this by raising both requests on the same clock, aimed at the same word, first as a host write against a DSP read and then as a host read against a DSP write. It judges the outcome by dsp_wait in the shared cycle and by the data each side sees. The DSP read must return the word the host just wrote, and the host read must return the value from before the DSP write. A matching case with the window disabled confirms that a host request then never makes the DSP wait.

// File: rtl/smw_pkg.sv
package smw_pkg;

   // control byte, field order follows the bit positions 2:0
   typedef struct packed {
      logic win_off;   // 1 = window not decoded
      logic run;       // 1 = DSP released from reset
      logic bank;      // window bank select
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam ctrl_t CTRL_RST = '{win_off: 1'b1, run: 1'b0, bank: 1'b0};

   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_HOST = 2'd1,
      OWN_DSP  = 2'd2
   } owner_e;

endpackage

// File: rtl/smw_ctrl.sv
module smw_ctrl
   import smw_pkg::*;
#(
   parameter int               IO_AW    = 3,
   parameter logic [IO_AW-1:0] CTRL_OFS = 3'd4,
   parameter logic [3:0]       XVER     = 4'h3,
   parameter logic             BTYPE    = 1'b0,
   parameter logic [1:0]       BVER     = 2'b10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [IO_AW-1:0] io_addr,
   input  logic [7:0]       io_wdata,
   output logic [7:0]       io_rdata,
   output ctrl_t            ctrl
);

   localparam logic [7:0] INFO_BYTE = {XVER, 1'b1, BTYPE, BVER};

   logic  hit;
   ctrl_t ctrl_q;
   ctrl_t ctrl_nxt;

   if (IO_AW < 1) begin : g_bad_io
      $error("smw_ctrl: IO_AW must be at least 1");
   end

   assign hit      = (io_addr == CTRL_OFS);
   // upper bits of the written byte fall away in the modulo
   assign ctrl_nxt = ctrl_t'(CTRL_W'(io_wdata % (1 << CTRL_W)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (io_wr && hit) begin
         ctrl_q <= ctrl_nxt;
      end
   end

   always_comb begin
      io_rdata = '0;
      if (io_rd && hit && !ctrl_q.run) begin
         io_rdata = INFO_BYTE;
      end
   end

   assign ctrl = ctrl_q;

   // R2
   run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q.run) |-> $past(io_wr && hit && io_wdata[1]));

   // R11
   info_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rdata != 8'h00) |-> (!ctrl_q.run && io_rd));

endmodule

// File: rtl/smw_map.sv
module smw_map #(
   parameter int              HOST_AW  = 15,
   parameter int              MEM_AW   = 15,
   parameter int              DSP_AW   = 16,
   parameter logic [DSP_AW-1:0] DSP_BASE = 16'h4000
) (
   input  logic              bank,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DSP_AW-1:0]  dsp_addr,
   output logic [MEM_AW-1:0]  host_phys,
   output logic [MEM_AW-1:0]  dsp_phys
);

   localparam int WORD_AW = HOST_AW - 1;

   logic [WORD_AW-1:0] host_word;

   if (MEM_AW != HOST_AW) begin : g_bad_aw
      $error("smw_map: memory word address must be host word bits plus bank bit");
   end
   if (DSP_AW < MEM_AW) begin : g_bad_dsp
      $error("smw_map: DSP address narrower than memory address");
   end

   // two host bytes per memory word
   assign host_word = WORD_AW'(host_addr >> 1);
   assign host_phys = {bank, host_word};

   // DSP address space starts at DSP_BASE
   assign dsp_phys  = MEM_AW'(dsp_addr - DSP_BASE);

endmodule

// File: rtl/smw_arb.sv
module smw_arb
   import smw_pkg::*;
#(
   parameter int HOST_DW = 16,
   parameter int MEM_DW  = 24,
   parameter int MEM_AW  = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                win_en,
   input  logic                hm_req,
   input  logic                hm_we,
   input  logic [HOST_DW/8-1:0] hm_be,
   input  logic [HOST_DW-1:0]  hm_wdata,
   input  logic [MEM_AW-1:0]   host_phys,
   output logic [HOST_DW-1:0]  hm_rdata,
   output logic                hm_rvalid,
   input  logic                dsp_req,
   input  logic                dsp_we,
   input  logic [MEM_DW-1:0]   dsp_wdata,
   input  logic [MEM_AW-1:0]   dsp_phys,
   output logic [MEM_DW-1:0]   dsp_rdata,
   output logic                dsp_rvalid,
   output logic                dsp_wait,
   output logic                mem_en,
   output logic                mem_we,
   output logic [MEM_AW-1:0]   mem_addr,
   output logic [MEM_DW/8-1:0] mem_be,
   output logic [MEM_DW-1:0]   mem_wdata,
   input  logic [MEM_DW-1:0]   mem_rdata
);

   localparam int MEM_LANES  = MEM_DW / 8;
   localparam int HOST_LANES = HOST_DW / 8;
   localparam int HID_LANES  = MEM_LANES - HOST_LANES;
   localparam int HID_W      = HID_LANES * 8;

   logic                 host_go;
   logic                 dsp_go;
   logic [MEM_LANES-1:0] host_be;
   logic [MEM_DW-1:0]    host_wword;
   owner_e               rd_own_q;

   if ((MEM_DW % 8) != 0 || (HOST_DW % 8) != 0) begin : g_bad_dw
      $error("smw_arb: data widths must be whole bytes");
   end
   if (HOST_DW >= MEM_DW) begin : g_bad_hid
      $error("smw_arb: host path must be narrower than the memory word");
   end

   // hidden low lanes are never written from the host side
   for (genvar i = 0; i < MEM_LANES; i++) begin : g_lane
      if (i < HID_LANES) begin : g_hid
         assign host_be[i] = 1'b0;
      end else begin : g_vis
         assign host_be[i] = hm_be[i-HID_LANES];
      end
   end

   assign host_wword = {hm_wdata, {HID_W{1'b0}}};

   // host has priority over the DSP
   assign host_go  = hm_req && win_en;
   assign dsp_go   = dsp_req && !host_go;
   assign dsp_wait = dsp_req && host_go;

   always_comb begin
      mem_en    = host_go || dsp_go;
      mem_we    = 1'b0;
      mem_addr  = dsp_phys;
      mem_be    = '1;
      mem_wdata = dsp_wdata;
      if (host_go) begin
         mem_we    = hm_we;
         mem_addr  = host_phys;
         mem_be    = host_be;
         mem_wdata = host_wword;
      end else if (dsp_go) begin
         mem_we    = dsp_we;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_own_q <= OWN_NONE;
      end else if (host_go && !hm_we) begin
         rd_own_q <= OWN_HOST;
      end else if (dsp_go && !dsp_we) begin
         rd_own_q <= OWN_DSP;
      end else begin
         rd_own_q <= OWN_NONE;
      end
   end

   assign hm_rvalid  = (rd_own_q == OWN_HOST);
   assign dsp_rvalid = (rd_own_q == OWN_DSP);
   assign hm_rdata   = hm_rvalid ? mem_rdata[MEM_DW-1:HID_W] : '0;
   assign dsp_rdata  = dsp_rvalid ? mem_rdata : '0;

   // R6
   host_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hm_rvalid |-> $past(hm_req && win_en && !hm_we));

   // R10
   dsp_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_rvalid |-> $past(dsp_req && !dsp_wait && !dsp_we));

   // R8
   win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hm_req && !win_en && !dsp_req) |-> !mem_en);

   // R7
   hidden_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && hm_req && win_en) |-> (mem_be[HID_LANES-1:0] == '0));

   // R9
   host_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hm_req && win_en && dsp_req) |-> (dsp_wait && mem_en));

endmodule

// File: rtl/smw_bridge.sv
module smw_bridge
   import smw_pkg::*;
#(
   parameter int                HOST_AW  = 15,
   parameter int                HOST_DW  = 16,
   parameter int                MEM_DW   = 24,
   parameter int                DSP_AW   = 16,
   parameter logic [DSP_AW-1:0] DSP_BASE = 16'h4000,
   parameter int                IO_AW    = 3,
   parameter logic [IO_AW-1:0]  CTRL_OFS = 3'd4,
   parameter logic [3:0]        XVER     = 4'h3,
   parameter logic              BTYPE    = 1'b0,
   parameter logic [1:0]        BVER     = 2'b10,
   localparam int               MEM_AW   = HOST_AW,
   localparam int               MEM_LN   = MEM_DW / 8,
   localparam int               HOST_LN  = HOST_DW / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [IO_AW-1:0]   io_addr,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   output logic               dsp_rst_n,
   input  logic               hm_req,
   input  logic               hm_we,
   input  logic [HOST_AW-1:0] hm_addr,
   input  logic [HOST_LN-1:0] hm_be,
   input  logic [HOST_DW-1:0] hm_wdata,
   output logic [HOST_DW-1:0] hm_rdata,
   output logic               hm_rvalid,
   input  logic               dsp_req,
   input  logic               dsp_we,
   input  logic [DSP_AW-1:0]  dsp_addr,
   input  logic [MEM_DW-1:0]  dsp_wdata,
   output logic [MEM_DW-1:0]  dsp_rdata,
   output logic               dsp_rvalid,
   output logic               dsp_wait,
   output logic               mem_en,
   output logic               mem_we,
   output logic [MEM_AW-1:0]  mem_addr,
   output logic [MEM_LN-1:0]  mem_be,
   output logic [MEM_DW-1:0]  mem_wdata,
   input  logic [MEM_DW-1:0]  mem_rdata
);

   ctrl_t             ctrl;
   logic [MEM_AW-1:0] host_phys;
   logic [MEM_AW-1:0] dsp_phys;

   smw_ctrl #(
      .IO_AW    (IO_AW),
      .CTRL_OFS (CTRL_OFS),
      .XVER     (XVER),
      .BTYPE    (BTYPE),
      .BVER     (BVER)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_wr    (io_wr),
      .io_rd    (io_rd),
      .io_addr  (io_addr),
      .io_wdata (io_wdata),
      .io_rdata (io_rdata),
      .ctrl     (ctrl)
   );

   smw_map #(
      .HOST_AW  (HOST_AW),
      .MEM_AW   (MEM_AW),
      .DSP_AW   (DSP_AW),
      .DSP_BASE (DSP_BASE)
   ) i_map (
      .bank      (ctrl.bank),
      .host_addr (hm_addr),
      .dsp_addr  (dsp_addr),
      .host_phys (host_phys),
      .dsp_phys  (dsp_phys)
   );

   smw_arb #(
      .HOST_DW (HOST_DW),
      .MEM_DW  (MEM_DW),
      .MEM_AW  (MEM_AW)
   ) i_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_en     (!ctrl.win_off),
      .hm_req     (hm_req),
      .hm_we      (hm_we),
      .hm_be      (hm_be),
      .hm_wdata   (hm_wdata),
      .host_phys  (host_phys),
      .hm_rdata   (hm_rdata),
      .hm_rvalid  (hm_rvalid),
      .dsp_req    (dsp_req),
      .dsp_we     (dsp_we),
      .dsp_wdata  (dsp_wdata),
      .dsp_phys   (dsp_phys),
      .dsp_rdata  (dsp_rdata),
      .dsp_rvalid (dsp_rvalid),
      .dsp_wait   (dsp_wait),
      .mem_en     (mem_en),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_be     (mem_be),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata)
   );

   assign dsp_rst_n = ctrl.run;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!dsp_rst_n && !mem_en));

endmodule

// File: tb/test_smw_bridge.sv
`timescale 1ns/1ps
module test_smw_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [2:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        dsp_rst_n;
   logic        hm_req = 1'b0, hm_we = 1'b0;
   logic [14:0] hm_addr = '0;
   logic [1:0]  hm_be = '0;
   logic [15:0] hm_wdata = '0;
   logic [15:0] hm_rdata;
   logic        hm_rvalid;
   logic        dsp_req = 1'b0, dsp_we = 1'b0;
   logic [15:0] dsp_addr = '0;
   logic [23:0] dsp_wdata = '0;
   logic [23:0] dsp_rdata;
   logic        dsp_rvalid, dsp_wait;
   logic        mem_en, mem_we;
   logic [14:0] mem_addr;
   logic [2:0]  mem_be;
   logic [23:0] mem_wdata;
   logic [23:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   smw_bridge i_smw_bridge (
      .clk(clk), .rst_n(rst_n),
      .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .dsp_rst_n(dsp_rst_n),
      .hm_req(hm_req), .hm_we(hm_we), .hm_addr(hm_addr), .hm_be(hm_be),
      .hm_wdata(hm_wdata), .hm_rdata(hm_rdata), .hm_rvalid(hm_rvalid),
      .dsp_req(dsp_req), .dsp_we(dsp_we), .dsp_addr(dsp_addr),
      .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata), .dsp_rvalid(dsp_rvalid),
      .dsp_wait(dsp_wait),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // sparse single-port memory model, one cycle read latency
   logic [23:0] mdl [int];
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            logic [23:0] w;
            w = mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 24'h0;
            if (mem_be[2]) w[23:16] = mem_wdata[23:16];
            if (mem_be[1]) w[15:8]  = mem_wdata[15:8];
            if (mem_be[0]) w[7:0]   = mem_wdata[7:0];
            mdl[int'(mem_addr)] = w;
         end else begin
            mem_rdata <= mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 24'h0;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [2:0] a, output logic [7:0] q);
      @(negedge clk);
      io_rd = 1'b1; io_addr = a;
      #1 q = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic host_write(input logic [14:0] a, input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      hm_req = 1'b1; hm_we = 1'b1; hm_addr = a; hm_be = be; hm_wdata = d;
      @(negedge clk);
      hm_req = 1'b0; hm_we = 1'b0;
   endtask

   task automatic host_read(input logic [14:0] a, output logic v, output logic [15:0] q);
      @(negedge clk);
      hm_req = 1'b1; hm_we = 1'b0; hm_addr = a;
      @(negedge clk);
      hm_req = 1'b0;
      #1 v = hm_rvalid; q = hm_rdata;
   endtask

   task automatic dsp_xfer(input logic we, input logic [15:0] a, input logic [23:0] d,
                           output logic [23:0] q);
      @(negedge clk);
      dsp_req = 1'b1; dsp_we = we; dsp_addr = a; dsp_wdata = d;
      #1;
      while (dsp_wait) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      dsp_req = 1'b0; dsp_we = 1'b0;
      #1 q = dsp_rdata;
   endtask

   task automatic t_reset;
      logic v; logic [15:0] q; logic [7:0] b;
      chk("R1 dsp_rst_n after reset", 32'(dsp_rst_n), 32'h0);
      host_read(15'h0000, v, q);
      chk("R1 window disabled after reset", 32'(v), 32'h0);
      io_read(3'd4, b);
      chk("R11 info byte in reset", 32'(b), 32'h3A);
      io_write(3'd4, 8'h02);
      chk("R2 run bit releases DSP", 32'(dsp_rst_n), 32'h1);
   endtask

   task automatic t_bank0;
      logic v; logic [15:0] q; logic [23:0] r;
      dsp_xfer(1'b1, 16'h5200, 24'hA1B2C3, r);
      dsp_xfer(1'b1, 16'h4000, 24'h123456, r);
      dsp_xfer(1'b1, 16'hBFFF, 24'hABCDEF, r);
      host_read(15'h2400, v, q);
      chk("R6 host rvalid", 32'(v), 32'h1);
      chk("R3 host 0x2400 -> DSP 0x5200", 32'(q), 32'hA1B2);
      host_read(15'h2401, v, q);
      chk("R3 odd byte same word", 32'(q), 32'hA1B2);
      host_read(15'h0000, v, q);
      chk("R5 low end of DSP range", 32'(q), 32'h1234);
   endtask

   task automatic t_lanes;
      logic [23:0] r;
      host_write(15'h2400, 2'b01, 16'h5566);
      dsp_xfer(1'b0, 16'h5200, 24'h0, r);
      chk("R7 low lane only", 32'(r), 32'hA166C3);
      chk("R10 dsp rvalid", 32'(dsp_rvalid), 32'h1);
      host_write(15'h2400, 2'b10, 16'h7788);
      dsp_xfer(1'b0, 16'h5200, 24'h0, r);
      chk("R7 high lane only", 32'(r), 32'h7766C3);
      host_write(15'h2401, 2'b11, 16'h99AA);
      dsp_xfer(1'b0, 16'h5200, 24'h0, r);
      chk("R7 both lanes, low byte kept", 32'(r), 32'h99AAC3);
   endtask

   task automatic t_bank1;
      logic v; logic [15:0] q; logic [23:0] r;
      dsp_xfer(1'b1, 16'h9200, 24'h0F1E2D, r);
      io_write(3'd4, 8'hFB);
      chk("R2 upper bits ignored", 32'(dsp_rst_n), 32'h1);
      host_read(15'h2400, v, q);
      chk("R4 bank 1 host 0x2400 -> DSP 0x9200", 32'(q), 32'h0F1E);
      host_read(15'h7FFE, v, q);
      chk("R5 high end of DSP range", 32'(q), 32'hABCD);
      host_write(15'h0000, 2'b11, 16'hBEEF);
      dsp_xfer(1'b0, 16'h8000, 24'h0, r);
      chk("R4 bank 1 write lands at 0x8000", 32'(r), 32'hBEEF00);
      dsp_xfer(1'b0, 16'h4000, 24'h0, r);
      chk("R4 bank 0 word untouched", 32'(r), 32'h123456);
      io_write(3'd0, 8'h00);
      chk("R2 other offset keeps run", 32'(dsp_rst_n), 32'h1);
      host_read(15'h2400, v, q);
      chk("R2 other offset keeps bank", 32'(q), 32'h0F1E);
   endtask

   task automatic t_window_off;
      logic v; logic [15:0] q; logic [23:0] r;
      io_write(3'd4, 8'h06);
      host_write(15'h2400, 2'b11, 16'hFFFF);
      host_read(15'h2400, v, q);
      chk("R8 no rvalid when disabled", 32'(v), 32'h0);
      chk("R8 rdata zero when disabled", 32'(q), 32'h0);
      dsp_xfer(1'b0, 16'h5200, 24'h0, r);
      chk("R8 write dropped when disabled", 32'(r), 32'h99AAC3);
      @(negedge clk);
      hm_req = 1'b1; hm_we = 1'b0; hm_addr = 15'h0;
      dsp_req = 1'b1; dsp_we = 1'b0; dsp_addr = 16'h5200;
      #1 chk("R8 disabled host never stalls DSP", 32'(dsp_wait), 32'h0);
      @(negedge clk);
      hm_req = 1'b0; dsp_req = 1'b0;
      #1 chk("R8 DSP served beside disabled host", 32'(dsp_rdata), 32'h99AAC3);
   endtask

   task automatic t_priority;
      logic v; logic [15:0] q; logic [23:0] r;
      io_write(3'd4, 8'h02);
      // host write against DSP read of the same word
      @(negedge clk);
      hm_req = 1'b1; hm_we = 1'b1; hm_addr = 15'h2400; hm_be = 2'b11; hm_wdata = 16'h1357;
      dsp_req = 1'b1; dsp_we = 1'b0; dsp_addr = 16'h5200;
      #1 chk("R9 DSP waits on collision", 32'(dsp_wait), 32'h1);
      @(negedge clk);
      hm_req = 1'b0; hm_we = 1'b0;
      #1 chk("R9 wait drops when host idle", 32'(dsp_wait), 32'h0);
      chk("R9 no DSP data during wait", 32'(dsp_rvalid), 32'h0);
      @(negedge clk);
      dsp_req = 1'b0;
      #1 chk("R9 stalled DSP read sees host data", 32'(dsp_rdata), 32'h1357C3);
      // host read against DSP write of the same word
      @(negedge clk);
      hm_req = 1'b1; hm_we = 1'b0; hm_addr = 15'h2400;
      dsp_req = 1'b1; dsp_we = 1'b1; dsp_addr = 16'h5200; dsp_wdata = 24'h246800;
      #1 chk("R9 DSP write waits", 32'(dsp_wait), 32'h1);
      @(negedge clk);
      hm_req = 1'b0;
      #1 v = hm_rvalid; q = hm_rdata;
      chk("R9 host served first", 32'(v), 32'h1);
      chk("R9 host read before DSP write", 32'(q), 32'h1357);
      @(negedge clk);
      dsp_req = 1'b0; dsp_we = 1'b0;
      dsp_xfer(1'b0, 16'h5200, 24'h0, r);
      chk("R9 stalled DSP write completes", 32'(r), 32'h246800);
   endtask

   task automatic t_info;
      logic [7:0] b;
      io_read(3'd4, b);
      chk("R11 info hidden while running", 32'(b), 32'h00);
      io_read(3'd3, b);
      chk("R11 other offset reads zero", 32'(b), 32'h00);
      io_write(3'd4, 8'h04);
      chk("R2 DSP back in reset", 32'(dsp_rst_n), 32'h0);
      io_read(3'd4, b);
      chk("R11 info byte again in reset", 32'(b), 32'h3A);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bank0();
      t_lanes();
      t_bank1();
      t_window_off();
      t_priority();
      t_info();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule